// File: doc/BRIEF.md
# Clock-Crossing Register Bridge

This block is a 32-bit memory-mapped slave that lives in the processor clock domain and replays every bus access as a transaction on a simple register port in a separate user clock domain. On the register side, a write is a one-cycle strobe that carries a word address, write data and byte-lane enables. A read is a one-cycle request carrying a word address. The register logic answers it some cycles later with read data and a read-valid strobe.

Only one command is in flight at any time, and one address path serves both directions. The bridge raises its wait-request output from the cycle after it accepts a command. It holds it there until the command has finished in the user domain, so the next bus access is stalled. Requests and completions cross the two domains as toggles that pass through two-stage synchronizers. The command fields stay frozen in registers until the other side answers.

Top module: `cdc_reg_bridge`

## Requirements
- R1: After both resets, bus_waitreq, bus_rdvalid, reg_wr and reg_rdreq are all low.
- R2: A bus write accepted while idle produces exactly one reg_wr pulse, one user cycle wide. That pulse carries reg_addr equal to the byte address divided by 4, together with the written data and byte enables.
- R3: bus_be[i] selects data bits 8*i+7 down to 8*i, and is passed unchanged to reg_be[i].
- R4: bus_waitreq is high from the cycle after a command is accepted until that command completes. While it is high the latched command does not change and no further bus command is taken.
- R5: On a write, bus_waitreq falls only after the user side has issued the write strobe. Writes issued back to back, each waiting on wait-request, all arrive, in issue order.
- R6: A bus read produces exactly one reg_rdreq pulse with the word address and no reg_wr. reg_wr and reg_rdreq are never high together.
- R7: A read completes on reg_rdvalid for any reply delay of zero or more user cycles. bus_rdata then holds the value that came with reg_rdvalid, bus_rdvalid is high for exactly one processor cycle, and bus_waitreq falls in that same cycle.
- R8: reg_rdvalid arriving while no read is outstanding is ignored. bus_rdvalid stays low, and the next read returns the register value, not the stray data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Processor-domain clock |
| cpu_rst_n | input | 1 | Processor-domain asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address of the bus access |
| bus_write | input | 1 | Bus write request |
| bus_wdata | input | DATA_W | Bus write data |
| bus_be | input | DATA_W/8 | Bus byte enables, one per lane |
| bus_read | input | 1 | Bus read request |
| bus_rdata | output | DATA_W | Read data returned to the bus |
| bus_rdvalid | output | 1 | One-cycle marker that bus_rdata is valid |
| bus_waitreq | output | 1 | Stalls the bus while a command is in flight |
| usr_clk | input | 1 | User-domain clock |
| usr_rst_n | input | 1 | User-domain asynchronous reset, active low |
| reg_addr | output | ADDR_W-2 | Register word address |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_wdata | output | DATA_W | Register write data |
| reg_be | output | DATA_W/8 | Register byte enables |
| reg_rdreq | output | 1 | One-cycle register read request |
| reg_rdata | input | DATA_W | Register read data from the user logic |
| reg_rdvalid | input | 1 | Marks reg_rdata valid for the outstanding read |

## Verification
The bench drives writes back to back, each one stalled behind the wait-request of the write before it. A bridge that dropped wait-request before the user side took the strobe would lose the later writes, or land them out of order in the modelled register file. Reads are answered with delays from zero up to forty user cycles. A bridge that used a fixed read latency would return stale data, or would release wait-request too early.

Partial byte-enable writes are read back afterwards, so a lane mapping that is swapped or dropped shows up as wrong bytes. A stray read-valid is injected while the bridge is idle. A design that accepted it would raise bus_rdvalid, or would hand the stray data to the next read.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  // Processor-side command phase
  typedef enum logic [1:0] {
    CP_IDLE = 2'd0,
    CP_WR   = 2'd1,
    CP_RD   = 2'd2
  } cpu_st_e;

  // User-side command phase
  typedef enum logic {
    US_IDLE = 1'b0,
    US_RDW  = 1'b1
  } usr_st_e;

  // Byte address to word address: drop the lane-select bits
  function automatic logic [63:0] byte_to_word(input logic [63:0] byte_addr,
                                               input int unsigned lane_bits);
    return byte_addr >> lane_bits;
  endfunction

endpackage

// File: rtl/tgl_sync.sv
// Synchronizes a toggle into the local clock and emits a one-cycle pulse
// on every change of the toggle.
module tgl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_in,
  output logic pulse
);
  localparam int SH_W = STAGES + 1;

  logic [SH_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SH_W-2:0], tgl_in};
  end

  assign pulse = sh[SH_W-1] ^ sh[SH_W-2];
endmodule

// File: rtl/bridge_cpu_port.sv
// Processor-domain half: accepts one bus command, freezes it, flips the
// request toggle and holds wait-request until the completion toggle returns.
module bridge_cpu_port
  import bridge_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_write,
  input  logic [DATA_W-1:0]        bus_wdata,
  input  logic [DATA_W/8-1:0]      bus_be,
  input  logic                     bus_read,
  output logic [DATA_W-1:0]        bus_rdata,
  output logic                     bus_rdvalid,
  output logic                     bus_waitreq,
  input  logic                     ack_pulse,
  input  logic [DATA_W-1:0]        usr_rdata,
  output logic                     req_tgl,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0] cmd_addr,
  output logic [DATA_W-1:0]        cmd_wdata,
  output logic [DATA_W/8-1:0]      cmd_be,
  output logic                     cmd_is_rd,
  output logic                     accept,
  output logic                     done
);
  localparam int LANE_BITS = $clog2(DATA_W / 8);
  localparam int WORD_AW   = ADDR_W - LANE_BITS;

  cpu_st_e st;
  logic [63:0] word_full;
  logic        word_hi_unused;

  assign word_full      = byte_to_word(64'(bus_addr), LANE_BITS);
  assign word_hi_unused = ^word_full[63:WORD_AW];

  assign accept      = (st == CP_IDLE) && (bus_write || bus_read);
  assign done        = (st != CP_IDLE) && ack_pulse;
  assign bus_waitreq = (st != CP_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= CP_IDLE;
      req_tgl     <= 1'b0;
      cmd_addr    <= '0;
      cmd_wdata   <= '0;
      cmd_be      <= '0;
      cmd_is_rd   <= 1'b0;
      bus_rdata   <= '0;
      bus_rdvalid <= 1'b0;
    end else begin
      bus_rdvalid <= 1'b0;
      if (accept) begin
        cmd_addr  <= word_full[WORD_AW-1:0];
        cmd_wdata <= bus_wdata;
        cmd_be    <= bus_be;
        cmd_is_rd <= !bus_write;
        req_tgl   <= ~req_tgl;
        st        <= bus_write ? CP_WR : CP_RD;
      end else if (done) begin
        st <= CP_IDLE;
        if (st == CP_RD) begin
          bus_rdata   <= usr_rdata;
          bus_rdvalid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bridge_usr_port.sv
// User-domain half: turns each request pulse into one register strobe,
// waits for read-valid on reads, and flips the completion toggle.
module bridge_usr_port
  import bridge_pkg::*;
#(
  parameter int WORD_AW = 14,
  parameter int DATA_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_pulse,
  input  logic [WORD_AW-1:0]   cmd_addr,
  input  logic [DATA_W-1:0]    cmd_wdata,
  input  logic [DATA_W/8-1:0]  cmd_be,
  input  logic                 cmd_is_rd,
  output logic [WORD_AW-1:0]   reg_addr,
  output logic                 reg_wr,
  output logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W/8-1:0]  reg_be,
  output logic                 reg_rdreq,
  input  logic [DATA_W-1:0]    reg_rdata,
  input  logic                 reg_rdvalid,
  output logic                 ack_tgl,
  output logic [DATA_W-1:0]    hold_rdata,
  output logic                 rd_capture
);
  usr_st_e st;
  logic    start;

  assign start      = req_pulse && (st == US_IDLE);
  assign rd_capture = (st == US_RDW) && reg_rdvalid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= US_IDLE;
      reg_addr   <= '0;
      reg_wr     <= 1'b0;
      reg_wdata  <= '0;
      reg_be     <= '0;
      reg_rdreq  <= 1'b0;
      ack_tgl    <= 1'b0;
      hold_rdata <= '0;
    end else begin
      reg_wr    <= 1'b0;
      reg_rdreq <= 1'b0;
      if (start) begin
        reg_addr  <= cmd_addr;
        reg_wdata <= cmd_wdata;
        reg_be    <= cmd_be;
        if (cmd_is_rd) begin
          reg_rdreq <= 1'b1;
          st        <= US_RDW;
        end else begin
          reg_wr  <= 1'b1;
          ack_tgl <= ~ack_tgl;
        end
      end else if (rd_capture) begin
        hold_rdata <= reg_rdata;
        ack_tgl    <= ~ack_tgl;
        st         <= US_IDLE;
      end
    end
  end
endmodule

// File: rtl/cdc_reg_bridge.sv
module cdc_reg_bridge #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                 cpu_clk,
  input  logic                                 cpu_rst_n,
  input  logic [ADDR_W-1:0]                    bus_addr,
  input  logic                                 bus_write,
  input  logic [DATA_W-1:0]                    bus_wdata,
  input  logic [DATA_W/8-1:0]                  bus_be,
  input  logic                                 bus_read,
  output logic [DATA_W-1:0]                    bus_rdata,
  output logic                                 bus_rdvalid,
  output logic                                 bus_waitreq,
  input  logic                                 usr_clk,
  input  logic                                 usr_rst_n,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0]   reg_addr,
  output logic                                 reg_wr,
  output logic [DATA_W-1:0]                    reg_wdata,
  output logic [DATA_W/8-1:0]                  reg_be,
  output logic                                 reg_rdreq,
  input  logic [DATA_W-1:0]                    reg_rdata,
  input  logic                                 reg_rdvalid
);
  localparam int LANES   = DATA_W / 8;
  localparam int WORD_AW = ADDR_W - $clog2(LANES);

  // Named internal events, also observed by the checker
  logic                 req_tgl, ack_tgl;
  logic                 req_pulse, ack_pulse;
  logic                 cpu_accept, cpu_done, rd_capture;
  logic [WORD_AW-1:0]   cmd_addr;
  logic [DATA_W-1:0]    cmd_wdata, hold_rdata;
  logic [LANES-1:0]     cmd_be;
  logic                 cmd_is_rd;

  bridge_cpu_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cpu (
    .clk(cpu_clk), .rst_n(cpu_rst_n),
    .bus_addr(bus_addr), .bus_write(bus_write), .bus_wdata(bus_wdata),
    .bus_be(bus_be), .bus_read(bus_read),
    .bus_rdata(bus_rdata), .bus_rdvalid(bus_rdvalid), .bus_waitreq(bus_waitreq),
    .ack_pulse(ack_pulse), .usr_rdata(hold_rdata),
    .req_tgl(req_tgl), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_be(cmd_be), .cmd_is_rd(cmd_is_rd),
    .accept(cpu_accept), .done(cpu_done)
  );

  tgl_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(usr_clk), .rst_n(usr_rst_n), .tgl_in(req_tgl), .pulse(req_pulse)
  );

  tgl_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(cpu_clk), .rst_n(cpu_rst_n), .tgl_in(ack_tgl), .pulse(ack_pulse)
  );

  bridge_usr_port #(.WORD_AW(WORD_AW), .DATA_W(DATA_W)) u_usr (
    .clk(usr_clk), .rst_n(usr_rst_n),
    .req_pulse(req_pulse), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_be(cmd_be), .cmd_is_rd(cmd_is_rd),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_be(reg_be), .reg_rdreq(reg_rdreq),
    .reg_rdata(reg_rdata), .reg_rdvalid(reg_rdvalid),
    .ack_tgl(ack_tgl), .hold_rdata(hold_rdata), .rd_capture(rd_capture)
  );
endmodule

// File: rtl/bridge_checker.sv
module bridge_checker #(
  parameter int WORD_AW = 14
) (
  input logic               cpu_clk,
  input logic               cpu_rst_n,
  input logic               usr_clk,
  input logic               usr_rst_n,
  input logic               bus_waitreq,
  input logic               bus_rdvalid,
  input logic               cpu_accept,
  input logic [WORD_AW-1:0] cmd_addr,
  input logic               reg_wr,
  input logic               reg_rdreq
);
  a_r4_busy_after_accept: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    cpu_accept |=> bus_waitreq);

  a_r4_cmd_frozen: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    (bus_waitreq && $past(bus_waitreq)) |-> $stable(cmd_addr));

  a_r7_rdvalid_single: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    bus_rdvalid |=> !bus_rdvalid);

  a_r8_rdvalid_ends_command: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    bus_rdvalid |-> $past(bus_waitreq));

  a_r2_wr_single: assert property (@(posedge usr_clk) disable iff (!usr_rst_n)
    reg_wr |=> !reg_wr);

  a_r6_rdreq_single: assert property (@(posedge usr_clk) disable iff (!usr_rst_n)
    reg_rdreq |=> !reg_rdreq);

  a_r6_exclusive: assert property (@(posedge usr_clk) disable iff (!usr_rst_n)
    !(reg_wr && reg_rdreq));
endmodule

bind cdc_reg_bridge bridge_checker #(.WORD_AW(WORD_AW)) u_chk (
  .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n),
  .usr_clk(usr_clk), .usr_rst_n(usr_rst_n),
  .bus_waitreq(bus_waitreq), .bus_rdvalid(bus_rdvalid),
  .cpu_accept(cpu_accept), .cmd_addr(cmd_addr),
  .reg_wr(reg_wr), .reg_rdreq(reg_rdreq)
);

// File: tb/sim_cdc_reg_bridge.sv
`timescale 1ns/1ps
module sim_cdc_reg_bridge;
  logic        cpu_clk = 0, usr_clk = 0;
  logic        cpu_rst_n = 0, usr_rst_n = 0;
  logic [15:0] bus_addr = '0;
  logic        bus_write = 0, bus_read = 0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_rdata;
  logic        bus_rdvalid, bus_waitreq;
  logic [13:0] reg_addr;
  logic        reg_wr, reg_rdreq;
  logic [31:0] reg_wdata;
  logic [3:0]  reg_be;
  logic [31:0] reg_rdata = '0;
  logic        reg_rdvalid = 0;

  always #5   cpu_clk = ~cpu_clk;   // 100 MHz
  always #3.5 usr_clk = ~usr_clk;

  cdc_reg_bridge u0 (.*);

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // ---------------- register-file model (user domain) ----------------
  logic [31:0] mem [16];
  int          wr_cnt = 0, rdq_cnt = 0;
  logic [13:0] last_addr;
  logic [31:0] last_data;
  logic [3:0]  last_be;
  int          rd_lat = 0, rd_left = 0;
  bit          rd_pend = 0;
  logic [3:0]  rd_word;
  int          stray_req = 0, stray_done = 0;

  initial for (int i = 0; i < 16; i++) mem[i] = '0;

  always @(posedge usr_clk) begin
    reg_rdvalid <= 1'b0;
    if (reg_wr) begin
      wr_cnt    <= wr_cnt + 1;
      last_addr <= reg_addr;
      last_data <= reg_wdata;
      last_be   <= reg_be;
      for (int i = 0; i < 4; i++)
        if (reg_be[i]) mem[reg_addr[3:0]][8*i +: 8] <= reg_wdata[8*i +: 8];
    end
    if (reg_rdreq) begin
      rdq_cnt <= rdq_cnt + 1;
      if (rd_lat == 0) begin
        reg_rdvalid <= 1'b1;
        reg_rdata   <= mem[reg_addr[3:0]];
      end else begin
        rd_pend <= 1; rd_left <= rd_lat; rd_word <= reg_addr[3:0];
      end
    end else if (rd_pend) begin
      if (rd_left == 1) begin
        reg_rdvalid <= 1'b1;
        reg_rdata   <= mem[rd_word];
        rd_pend     <= 0;
      end
      rd_left <= rd_left - 1;
    end else if (stray_req != stray_done) begin
      reg_rdvalid <= 1'b1;
      reg_rdata   <= 32'hDEAD_BEEF;
      stray_done  <= stray_done + 1;
    end
  end

  int rdv_total = 0;
  always @(negedge cpu_clk) if (bus_rdvalid) rdv_total++;

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drives one command, returns at the negedge after the accepting edge
  task automatic bus_issue(input bit rd, input logic [15:0] a,
                           input logic [31:0] d, input logic [3:0] be);
    @(negedge cpu_clk);
    bus_addr = a; bus_wdata = d; bus_be = be;
    bus_write = !rd; bus_read = rd;
    for (int n = 0; n < 1000 && bus_waitreq; n++) @(negedge cpu_clk);
    @(negedge cpu_clk);
    bus_write = 0; bus_read = 0;
  endtask

  // Waits for completion; reports read data and rdvalid width
  task automatic wait_idle(output int rdv_cyc, output logic [31:0] rdat, output int busy);
    rdv_cyc = 0; rdat = 'x; busy = 0;
    for (int n = 0; n < 2000; n++) begin
      if (bus_rdvalid) begin rdv_cyc++; rdat = bus_rdata; end
      if (!bus_waitreq) break;
      busy++;
      @(negedge cpu_clk);
    end
    @(negedge cpu_clk);
    if (bus_rdvalid) rdv_cyc++;
  endtask

  typedef struct packed {
    logic        rd;
    logic [15:0] a;
    logic [31:0] d;
    logic [3:0]  be;
    logic [7:0]  lat;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{1'b0, 16'h0000, 32'h1122_3344, 4'hF, 8'd0, 32'h0},
    '{1'b0, 16'h0004, 32'hAABB_CCDD, 4'hF, 8'd0, 32'h0},
    '{1'b0, 16'h0004, 32'h0000_00EE, 4'h1, 8'd0, 32'h0},
    '{1'b0, 16'h003C, 32'h5A5A_5A5A, 4'hC, 8'd0, 32'h0},
    '{1'b1, 16'h0000, 32'h0,         4'h0, 8'd0, 32'h1122_3344},
    '{1'b1, 16'h0004, 32'h0,         4'h0, 8'd3, 32'hAABB_CCEE},
    '{1'b1, 16'h003C, 32'h0,         4'h0, 8'd1, 32'h5A5A_0000},
    '{1'b0, 16'h0008, 32'h1234_5678, 4'h6, 8'd0, 32'h0},
    '{1'b1, 16'h0008, 32'h0,         4'h0, 8'd5, 32'h0034_5600},
    '{1'b1, 16'h000C, 32'h0,         4'h0, 8'd2, 32'h0}
  };

  // ---------------- watchdog ----------------
  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    int          rdv, busy, w0, q0, r0;
    logic [31:0] rdat;

    #23 usr_rst_n = 1;
    #14 cpu_rst_n = 1;
    @(negedge cpu_clk); @(negedge cpu_clk);
    // R1 reset state
    chk("R1 waitreq", {31'b0, bus_waitreq}, 32'd0);
    chk("R1 rdvalid", {31'b0, bus_rdvalid}, 32'd0);
    chk("R1 reg_wr",  {31'b0, reg_wr},      32'd0);
    chk("R1 rdreq",   {31'b0, reg_rdreq},   32'd0);

    // Vector table
    foreach (VEC[i]) begin
      w0 = wr_cnt; q0 = rdq_cnt; r0 = rdv_total;
      rd_lat = int'(VEC[i].lat);
      bus_issue(VEC[i].rd, VEC[i].a, VEC[i].d, VEC[i].be);
      chk("R4 waitreq after accept", {31'b0, bus_waitreq}, 32'd1);
      wait_idle(rdv, rdat, busy);
      if (!VEC[i].rd) begin
        chk("R2 one write strobe", 32'(wr_cnt - w0), 32'd1);
        chk("R2 word address", {18'b0, last_addr}, {18'b0, VEC[i].a[15:2]});
        chk("R2 write data", last_data, VEC[i].d);
        chk("R3 byte enables", {28'b0, last_be}, {28'b0, VEC[i].be});
        chk("R5 no read traffic on write", 32'(rdq_cnt - q0 + rdv_total - r0), 32'd0);
      end else begin
        chk("R6 one read request", 32'(rdq_cnt - q0), 32'd1);
        chk("R6 no write on read", 32'(wr_cnt - w0), 32'd0);
        chk("R7 read data", rdat, VEC[i].exp);
        chk("R7 rdvalid one cycle", 32'(rdv), 32'd1);
      end
    end

    // R5 back-to-back writes, two hitting the same word to prove order
    w0 = wr_cnt;
    bus_issue(0, 16'h0010, 32'h0000_0001, 4'hF);
    bus_issue(0, 16'h0014, 32'h0000_0002, 4'hF);
    bus_issue(0, 16'h0010, 32'h0000_0003, 4'hF);
    bus_issue(0, 16'h0018, 32'h0000_0004, 4'hF);
    wait_idle(rdv, rdat, busy);
    chk("R5 all back-to-back writes delivered", 32'(wr_cnt - w0), 32'd4);
    rd_lat = 0;
    bus_issue(1, 16'h0010, 32'h0, 4'h0); wait_idle(rdv, rdat, busy);
    chk("R5 later write wins", rdat, 32'h0000_0003);
    bus_issue(1, 16'h0018, 32'h0, 4'h0); wait_idle(rdv, rdat, busy);
    chk("R5 last write landed", rdat, 32'h0000_0004);

    // R8 stray read-valid while idle
    r0 = rdv_total;
    stray_req = stray_req + 1;
    repeat (20) @(negedge cpu_clk);
    chk("R8 stray rdvalid ignored", 32'(rdv_total - r0), 32'd0);
    bus_issue(1, 16'h0014, 32'h0, 4'h0); wait_idle(rdv, rdat, busy);
    chk("R8 next read not stray data", rdat, 32'h0000_0002);

    // R7 long reply delay keeps the bus stalled
    rd_lat = 40;
    bus_issue(1, 16'h0000, 32'h0, 4'h0); wait_idle(rdv, rdat, busy);
    chk("R7 long-delay read data", rdat, 32'h1122_3344);
    chk("R4 stalled through long delay", {31'b0, busy >= 28}, 32'd1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule